// File: doc/BRIEF.md
# Elastic Audio Sample Buffer

This block decouples an incoming stereo sample stream from local playback. Samples arrive on the write clock, which is derived from the incoming bit clock. They are stored in a small dual-clock memory and played out on the local master clock. The buffer size is set in milliseconds and converted into a word count from the selected sample rate.

After a configuration is applied, the block first collects samples. Playback starts only when the buffer holds half of its configured depth. From then on, every playback tick removes one sample. An outside rate-tracking loop watches the reported fill level and steers the master clock so that the level stays near half full. The block itself never drops or repeats samples to correct drift. Only a true overflow or a true starvation does that, and each one raises its own sticky flag.

Top module: `audio_elastic_fifo`

## Requirements
- R1: While either reset is asserted, out_valid, playing, both flags, both sample outputs and fill_level are zero.
- R2: The capacity in stereo words is (depth_ms_code+1) × (BASE_WORDS << rate_sel). With default parameters, code 0 at rate 0 gives 8 words, and code 1 at rate 1 gives 32 words.
- R3: A write-side sample is stored only while the write-side fill (write pointer minus synchronized read pointer) is below capacity. At or above capacity it is discarded, and overrun_flag is set and stays set.
- R4: After reset or a flush, playing is low and out_valid stays low. playing rises at the first read-clock edge where the read-side fill is at least half the capacity.
- R5: While playing, a play_tick with a non-empty buffer returns the oldest unread sample on out_left/out_right, with out_valid high one read-clock edge later. Samples come out in arrival order.
- R6: While playing, a play_tick with an empty buffer returns zeros with out_valid high and sets underrun_flag. The flag stays set until the next flush.
- R7: fill_level equals the synchronized write pointer minus the read pointer. When the clocks are equal, a write accepted at one edge shows up in fill_level after the second following edge.
- R8: Changing rate_sel or depth_ms_code flushes the buffer. The read side drops all unread samples, returns to pre-fill and clears underrun_flag at the next read edge. overrun_flag clears once the change has crossed to the write side.
- R9: During pre-fill, play_tick is ignored: fill_level does not change and out_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock, derived from the incoming bit clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| in_valid | input | 1 | A new stereo sample is present |
| in_left | input | SAMPLE_W | Left sample word |
| in_right | input | SAMPLE_W | Right sample word |
| rd_clk | input | 1 | Local master (playback) clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rate_sel | input | RATE_W | Sample-rate selection, read-clock domain |
| depth_ms_code | input | MS_CODE_W | Buffer depth in milliseconds minus one, read-clock domain |
| play_tick | input | 1 | Request for one sample in playback |
| out_left | output | SAMPLE_W | Played left sample |
| out_right | output | SAMPLE_W | Played right sample |
| out_valid | output | 1 | Output sample updated this cycle |
| fill_level | output | ADDR_W+1 | Read-side fill in words, for the rate-tracking loop |
| playing | output | 1 | Pre-fill is complete and playback is active |
| underrun_flag | output | 1 | Sticky: a tick found the buffer empty |
| overrun_flag | output | 1 | Sticky (write domain): a sample was discarded |

## Verification
The hardest cases to reach are the exact cycles where the buffer tips into overrun or underrun. At those cycles the decision depends on a pointer that is two synchronizer stages stale, so the arrival pattern alone does not predict the outcome.

The bench drives both domains from one clock and creates the drift by write and read cadences that differ slightly. It first writes faster than it reads until samples are discarded, then reads faster than it writes until playback starves. A behavioural model that carries the synchronizer delay as plain counters predicts each flag edge and each sample value cycle by cycle. A single isolated write checks the visibility latency, and a configuration change with a tick held high checks the flush and the ignored ticks.

// File: rtl/aef_pkg.sv
package aef_pkg;

   typedef enum logic {
      ST_PREFILL = 1'b0,
      ST_PLAY    = 1'b1
   } play_state_t;

   // Words held for a depth code and rate selection.
   function automatic int unsigned depth_words(input int unsigned ms_code,
                                               input int unsigned rate,
                                               input int unsigned base);
      return (ms_code + 1) * (base << rate);
   endfunction

endpackage

// File: rtl/aef_sync.sv
module aef_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("aef_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/aef_store.sv
module aef_store #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int ENTRIES = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [ENTRIES];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/aef_wr_side.sv
module aef_wr_side #(
   parameter int ADDR_W      = 8,
   parameter int CFG_W       = 4,
   parameter int RATE_W      = 2,
   parameter int BASE_WORDS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CFG_W-1:0]  cfg_src,
   input  logic [ADDR_W:0]   rgray_src,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W:0]   wgray,
   output logic              overrun
);

   localparam int PTR_W = ADDR_W + 1;

   logic [PTR_W-1:0] wptr, wnxt, rsync, rbin, fill, depth;
   logic [CFG_W-1:0] cfg_s, cfg_q;
   logic             full, chg;

   function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
      logic [PTR_W-1:0] b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   aef_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk(clk), .rst_n(rst_n), .d(rgray_src), .q(rsync));

   aef_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
      .clk(clk), .rst_n(rst_n), .d(cfg_src), .q(cfg_s));

   always_comb begin
      rbin    = g2b(rsync);
      fill    = wptr - rbin;
      depth   = PTR_W'(aef_pkg::depth_words(32'(cfg_s[CFG_W-1:RATE_W]),
                                            32'(cfg_s[RATE_W-1:0]), BASE_WORDS));
      full    = fill >= depth;
      chg     = cfg_s != cfg_q;
      wr_en   = in_valid && !full;
      wnxt    = wptr + PTR_W'(1);
      wr_addr = wptr[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         wgray   <= '0;
         cfg_q   <= '0;
         overrun <= 1'b0;
      end else begin
         cfg_q   <= cfg_s;
         overrun <= (overrun && !chg) || (in_valid && full);
         if (wr_en) begin
            wptr  <= wnxt;
            wgray <= wnxt ^ (wnxt >> 1);
         end
      end
   end

   assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && full) |=> overrun)
      else $error("overrun not flagged on discarded sample");

   assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !chg) |=> overrun)
      else $error("overrun flag dropped without a flush");

endmodule

// File: rtl/aef_rd_side.sv
module aef_rd_side #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int CFG_W       = 4,
   parameter int RATE_W      = 2,
   parameter int BASE_WORDS  = 8,
   parameter int MAX_WORDS   = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_in,
   input  logic              play_tick,
   input  logic [ADDR_W:0]   wgray_src,
   input  logic [DATA_W-1:0] mem_q,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W:0]   rgray,
   output logic [CFG_W-1:0]  cfg_q,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic [ADDR_W:0]   fill,
   output logic              playing,
   output logic              underrun
);

   import aef_pkg::*;

   localparam int PTR_W = ADDR_W + 1;

   logic [PTR_W-1:0] rptr, rnxt, wsync, wbin, depth;
   logic             chg, empty;
   play_state_t      state;

   function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
      logic [PTR_W-1:0] b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   aef_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk(clk), .rst_n(rst_n), .d(wgray_src), .q(wsync));

   always_comb begin
      wbin    = g2b(wsync);
      fill    = wbin - rptr;
      depth   = PTR_W'(depth_words(32'(cfg_q[CFG_W-1:RATE_W]),
                                   32'(cfg_q[RATE_W-1:0]), BASE_WORDS));
      chg     = cfg_in != cfg_q;
      empty   = fill == '0;
      rnxt    = rptr + PTR_W'(1);
      rd_addr = rptr[ADDR_W-1:0];
      playing = state == ST_PLAY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr      <= '0;
         rgray     <= '0;
         cfg_q     <= '0;
         state     <= ST_PREFILL;
         out_data  <= '0;
         out_valid <= 1'b0;
         underrun  <= 1'b0;
      end else begin
         cfg_q <= cfg_in;
         if (chg) begin
            rptr      <= wbin;
            rgray     <= wbin ^ (wbin >> 1);
            state     <= ST_PREFILL;
            underrun  <= 1'b0;
            out_valid <= 1'b0;
         end else if (state == ST_PREFILL) begin
            out_valid <= 1'b0;
            if (fill >= (depth >> 1)) state <= ST_PLAY;
         end else begin
            out_valid <= play_tick;
            if (play_tick) begin
               if (empty) begin
                  out_data <= '0;
                  underrun <= 1'b1;
               end else begin
                  out_data <= mem_q;
                  rptr     <= rnxt;
                  rgray    <= rnxt ^ (rnxt >> 1);
               end
            end
         end
      end
   end

   assert_prefill_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PREFILL) |=> !out_valid)
      else $error("sample emitted during pre-fill");

   assert_underrun_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PLAY && play_tick && empty && !chg) |=>
         (out_valid && out_data == '0 && underrun))
      else $error("empty tick did not yield a flagged zero sample");

   assert_underrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !chg) |=> underrun)
      else $error("underrun flag dropped without a flush");

   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> (state == ST_PREFILL && !underrun && !out_valid))
      else $error("configuration change did not restart pre-fill");

   assert_fill_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= PTR_W'(MAX_WORDS))
      else $error("fill level beyond largest capacity");

endmodule

// File: rtl/audio_elastic_fifo.sv
module audio_elastic_fifo #(
   parameter int SAMPLE_W    = 16,
   parameter int RATE_W      = 2,
   parameter int MS_CODE_W   = 2,
   parameter int BASE_WORDS  = 8,
   parameter int SYNC_STAGES = 2,
   localparam int MAX_WORDS  = (1 << MS_CODE_W) * (BASE_WORDS << ((1 << RATE_W) - 1)),
   localparam int ADDR_W     = $clog2(MAX_WORDS)
) (
   input  logic                 wr_clk,
   input  logic                 wr_rst_n,
   input  logic                 in_valid,
   input  logic [SAMPLE_W-1:0]  in_left,
   input  logic [SAMPLE_W-1:0]  in_right,
   input  logic                 rd_clk,
   input  logic                 rd_rst_n,
   input  logic [RATE_W-1:0]    rate_sel,
   input  logic [MS_CODE_W-1:0] depth_ms_code,
   input  logic                 play_tick,
   output logic [SAMPLE_W-1:0]  out_left,
   output logic [SAMPLE_W-1:0]  out_right,
   output logic                 out_valid,
   output logic [ADDR_W:0]      fill_level,
   output logic                 playing,
   output logic                 underrun_flag,
   output logic                 overrun_flag
);

   localparam int DATA_W = 2 * SAMPLE_W;
   localparam int CFG_W  = MS_CODE_W + RATE_W;

   if (SAMPLE_W < 1) begin : g_bad_sample
      $error("audio_elastic_fifo: SAMPLE_W must be positive");
   end
   if (BASE_WORDS < 2) begin : g_bad_base
      $error("audio_elastic_fifo: BASE_WORDS must be at least 2");
   end
   if (RATE_W < 1 || MS_CODE_W < 1) begin : g_bad_cfg
      $error("audio_elastic_fifo: configuration fields need at least one bit");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [ADDR_W:0]   wgray, rgray;
   logic [CFG_W-1:0]  cfg_q;
   logic [DATA_W-1:0] mem_q, out_data;

   aef_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wclk(wr_clk), .we(wr_en), .waddr(wr_addr), .wdata({in_left, in_right}),
      .raddr(rd_addr), .rdata(mem_q));

   aef_wr_side #(
      .ADDR_W(ADDR_W), .CFG_W(CFG_W), .RATE_W(RATE_W),
      .BASE_WORDS(BASE_WORDS), .SYNC_STAGES(SYNC_STAGES)
   ) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .cfg_src(cfg_q),
      .rgray_src(rgray), .wr_en(wr_en), .wr_addr(wr_addr), .wgray(wgray),
      .overrun(overrun_flag));

   aef_rd_side #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .RATE_W(RATE_W),
      .BASE_WORDS(BASE_WORDS), .MAX_WORDS(MAX_WORDS), .SYNC_STAGES(SYNC_STAGES)
   ) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .cfg_in({depth_ms_code, rate_sel}),
      .play_tick(play_tick), .wgray_src(wgray), .mem_q(mem_q), .rd_addr(rd_addr),
      .rgray(rgray), .cfg_q(cfg_q), .out_data(out_data), .out_valid(out_valid),
      .fill(fill_level), .playing(playing), .underrun(underrun_flag));

   assign out_left  = out_data[DATA_W-1:SAMPLE_W];
   assign out_right = out_data[SAMPLE_W-1:0];

endmodule

// File: tb/tb_audio_elastic_fifo.sv
`timescale 1ns/1ps
module tb_audio_elastic_fifo;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, play_tick;
   logic [15:0] in_left, in_right, out_left, out_right;
   logic [1:0]  rate_sel, ms_code;
   logic        out_valid, playing, underrun_flag, overrun_flag;
   logic [8:0]  fill_level;

   int checks = 0, failures = 0;
   bit cmp_en = 0;
   int seq = 1;

   always #10 clk = ~clk;

   audio_elastic_fifo dut (
      .wr_clk(clk), .wr_rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
      .in_right(in_right), .rd_clk(clk), .rd_rst_n(rst_n), .rate_sel(rate_sel),
      .depth_ms_code(ms_code), .play_tick(play_tick), .out_left(out_left),
      .out_right(out_right), .out_valid(out_valid), .fill_level(fill_level),
      .playing(playing), .underrun_flag(underrun_flag), .overrun_flag(overrun_flag));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Capacity from R2, computed independently.
   function automatic int words(input logic [3:0] c);
      return (int'(c[3:2]) + 1) * (8 << c[1:0]);
   endfunction

   // Behavioural reference: counters, delayed copies, associative store.
   int          m_w = 0, m_r = 0, ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
   logic [3:0]  rcq = 0, wc1 = 0, wc2 = 0, wcq = 0;
   bit          m_play = 0, m_und = 0, m_ovr = 0, m_val = 0;
   logic [31:0] m_out = 0;
   logic [31:0] dm [int];

   always @(posedge clk) begin
      if (rst_n) begin
         automatic int         fw    = m_w - rs2;
         automatic bit         chgw  = wc2 != wcq;
         automatic bit         drop  = in_valid && fw >= words(wc2);
         automatic bit         acc   = in_valid && !drop;
         automatic int         fr    = ws2 - m_r;
         automatic logic [3:0] cfg   = {ms_code, rate_sel};
         automatic int         w_old = m_w;
         automatic int         r_old = m_r;
         automatic logic [3:0] rq_o  = rcq;
         automatic logic [3:0] wc2_o = wc2;
         if (cfg != rcq) begin
            m_r = ws2; m_play = 0; m_und = 0; m_val = 0;
         end else if (!m_play) begin
            m_val = 0;
            if (fr >= words(rcq) / 2) m_play = 1;
         end else begin
            m_val = play_tick;
            if (play_tick) begin
               if (fr == 0) begin m_out = 0; m_und = 1; end
               else begin m_out = dm[m_r]; m_r++; end
            end
         end
         rcq = cfg;
         ws2 = ws1; ws1 = w_old; rs2 = rs1; rs1 = r_old;
         wcq = wc2_o; wc2 = wc1; wc1 = rq_o;
         m_ovr = (m_ovr && !chgw) || drop;
         if (acc) begin dm[w_old] = {in_left, in_right}; m_w++; end
      end
   end

   int prev_fill = 0;
   bit prev_play = 0;

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R5", "out_left",  int'(out_left),  int'(m_out[31:16]));
         chk("R5", "out_right", int'(out_right), int'(m_out[15:0]));
         chk("R4", "out_valid", int'(out_valid), int'(m_val));
         chk("R4", "playing",   int'(playing),   int'(m_play));
         chk("R7", "fill_level", int'(fill_level), ws2 - m_r);
         chk("R6", "underrun_flag", int'(underrun_flag), int'(m_und));
         chk("R3", "overrun_flag",  int'(overrun_flag),  int'(m_ovr));
         if (playing && !prev_play)
            chk("R2", "fill at playback start", prev_fill, words({ms_code, rate_sel}) / 2);
         prev_fill = int'(fill_level);
         prev_play = playing;
      end
   end

   task automatic run(input int n, input int wper, input int rper,
                      input int wskip, input int rskip);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = (wper > 0) && (i % wper == 0) &&
                     !(wskip > 0 && (i / wper) % wskip == wskip - 1);
         play_tick = (rper > 0) && (i % rper == 0) &&
                     !(rskip > 0 && (i / rper) % rskip == rskip - 1);
         if (in_valid) begin
            in_left  = 16'(seq);
            in_right = ~16'(seq);
            seq++;
         end
      end
      @(negedge clk);
      in_valid = 0;
      play_tick = 0;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; in_valid = 0; play_tick = 0; in_left = 0; in_right = 0;
      rate_sel = 0; ms_code = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "playing", int'(playing), 0);
      chk("R1", "fill_level", int'(fill_level), 0);
      chk("R1", "flags", int'({underrun_flag, overrun_flag}), 0);
      chk("R1", "out samples", int'({out_left, out_right}), 0);
      rst_n = 1;
      cmp_en = 1;

      // R3: writes outpace reads into the 8-word buffer
      run(500, 4, 5, 0, 0);
      chk("R3", "overrun reached", int'(overrun_flag), 1);
      // R6: reads outpace writes until starvation
      run(500, 6, 4, 0, 0);
      chk("R6", "underrun reached", int'(underrun_flag), 1);

      // R8: quiet, then new configuration (32 words)
      run(12, 0, 0, 0, 0);
      ms_code = 1; rate_sel = 1;
      run(8, 0, 0, 0, 0);
      chk("R8", "playing after flush", int'(playing), 0);
      chk("R8", "underrun cleared", int'(underrun_flag), 0);
      chk("R8", "overrun cleared", int'(overrun_flag), 0);
      chk("R8", "fill after flush", int'(fill_level), 0);

      // R7: one write becomes visible after the second following edge
      @(negedge clk);
      in_valid = 1; in_left = 16'(seq); in_right = ~16'(seq); seq++;
      @(negedge clk);
      in_valid = 0;
      chk("R7", "fill edge+0", int'(fill_level), 0);
      @(negedge clk);
      chk("R7", "fill edge+1", int'(fill_level), 0);
      @(negedge clk);
      chk("R7", "fill edge+2", int'(fill_level), 1);

      // R9: ticks during pre-fill change nothing
      play_tick = 1;
      repeat (6) @(negedge clk);
      play_tick = 0;
      chk("R9", "fill unchanged", int'(fill_level), 1);
      chk("R9", "no output", int'(out_valid), 0);

      // R5: long runs with slight drift either way
      run(3000, 4, 4, 0, 64);
      run(2000, 4, 4, 64, 0);
      chk("R3", "no overrun in drift run", int'(overrun_flag), 0);

      cmp_en = 0;
      summary();
      $finish;
   end

endmodule